// File: doc/BRIEF.md
# In-Order Completion and Retire Buffer

This block tracks instructions that a multi-issue pipeline has dispatched. Each dispatch group asks for a number of consecutive slots. The group is taken whole or refused whole, and it gets slot indices in program order. Functional units with different latencies report results back out of order. Each report carries the slot index and the result. The oldest end of the buffer then hands finished results to the register file strictly in program order, up to a fixed number of lanes per cycle.

Completion and retirement are two separate phases. An instruction that does not write memory retires in the same cycle that it completes. A store is moved at completion into a small in-order retire queue. It stays there until the memory system acknowledges the write. When that queue has no room, completion stops at the first store that cannot be placed.

An interrupt request stops all new allocation. Entries already in flight keep draining. Once the buffer and the retire queue are both empty, the block raises a one-cycle indication that the state is saved, and after that allocation opens again.

Top module: `commit_retire_buf`

## Requirements
- R1: A request of `alloc_cnt` slots is granted (`alloc_grant`=1) exactly when the mode is running, `irq_req` is low, `alloc_cnt` is nonzero and the free slot count (DEPTH minus occupancy, measured at the start of the cycle) is at least `alloc_cnt`. A grant takes all requested slots and a refusal takes none. `alloc_base` gives the slot that the first lane receives. Later lanes get the following indices modulo DEPTH.
- R2: An entry becomes eligible to complete only after a finish report naming its index has been accepted. An entry with no report holds back itself and every younger entry.
- R3: Completion lanes carry the oldest entries in program order. Lane 0 carries the oldest, and `cm_valid` always has the form of a contiguous run of ones starting at bit 0.
- R4: The number of entries completed in a cycle equals the length of the run of finished entries at the head, capped at COMMIT_W.
- R5: Each valid completion lane shows the destination index supplied at allocation and the result data from that entry's finish report.
- R6: A completed store enters the retire queue in order, and its lane shows `cm_store`=1. `mem_req_valid` shows that the queue is not empty, and `mem_req_data`/`mem_req_dest` belong to the oldest queued store. The store leaves the queue on a cycle with `mem_ack`=1.
- R7: `retire_cnt` equals the number of non-store entries completed in the cycle, plus one if a queued store is acknowledged in that cycle.
- R8: A store completes only if the retire queue has a free slot left for it, counted at the start of the cycle and after the earlier stores of the same cycle. Otherwise the completion run stops at that store. The retire queue never holds more than RQ_DEPTH stores.
- R9: From the cycle in which `irq_req` is seen while running, no allocation is granted until the drain has finished.
- R10: After an interrupt request, `irq_saved` goes high for exactly one cycle, and only once the buffer and the retire queue are both empty. In the next cycle allocation can be granted again.
- R11: After reset the buffer and the queue are empty. `cm_valid` is 0, `mem_req_valid` is 0, `irq_saved` is 0 and `alloc_base` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_cnt | input | $clog2(ISSUE_W+1) | Number of slots requested this cycle |
| alloc_store | input | ISSUE_W | Per-lane flag marking a memory-writing instruction |
| alloc_dest | input | ISSUE_W*REG_W | Per-lane destination register index |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_base | output | $clog2(DEPTH) | Slot index given to lane 0 of the request |
| fin_valid | input | FIN_W | Per-port finish report valid |
| fin_idx | input | FIN_W*$clog2(DEPTH) | Per-port slot index of the finished entry |
| fin_data | input | FIN_W*DATA_W | Per-port result value |
| cm_valid | output | COMMIT_W | Completion lane valid |
| cm_dest | output | COMMIT_W*REG_W | Completion lane destination index |
| cm_data | output | COMMIT_W*DATA_W | Completion lane result |
| cm_store | output | COMMIT_W | Completion lane is a store |
| mem_req_valid | output | 1 | Oldest queued store awaiting its memory write |
| mem_req_data | output | DATA_W | Data of the oldest queued store |
| mem_req_dest | output | REG_W | Index field of the oldest queued store |
| mem_ack | input | 1 | Memory write of the oldest queued store done |
| retire_cnt | output | $clog2(COMMIT_W+2) | Instructions retired this cycle |
| irq_req | input | 1 | Interrupt request |
| irq_saved | output | 1 | Drain finished, state saved (one cycle) |

## Verification
The bench builds the block with DEPTH 8, ISSUE_W 3, COMMIT_W 2, FIN_W 2, RQ_DEPTH 2, REG_W 4 and DATA_W 16. With only eight slots, pointer wrap-around and refusal on a full buffer come up within a few requests. A completion width of two lets a run of three finished entries show the cap. A retire queue of two fills after two unacknowledged stores, so the completion stall can be reached directly. All six finish orders of a three-entry group are enumerated, and long mixed sweeps with interrupt drains, taken both with entries in flight and with an empty buffer, are compared against an arithmetic model.

// File: rtl/commit_retire_buf.sv
module commit_retire_buf #(
  parameter int DEPTH    = 16,
  parameter int ISSUE_W  = 7,
  parameter int COMMIT_W = 4,
  parameter int FIN_W    = 4,
  parameter int RQ_DEPTH = 4,
  parameter int REG_W    = 6,
  parameter int DATA_W   = 32,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int REQ_W    = $clog2(ISSUE_W + 1),
  localparam int RQ_IDX_W = $clog2(RQ_DEPTH),
  localparam int RQ_CNT_W = $clog2(RQ_DEPTH + 1),
  localparam int CMC_W    = $clog2(COMMIT_W + 2)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [REQ_W-1:0]           alloc_cnt,
  input  logic [ISSUE_W-1:0]         alloc_store,
  input  logic [ISSUE_W*REG_W-1:0]   alloc_dest,
  output logic                       alloc_grant,
  output logic [IDX_W-1:0]           alloc_base,
  input  logic [FIN_W-1:0]           fin_valid,
  input  logic [FIN_W*IDX_W-1:0]     fin_idx,
  input  logic [FIN_W*DATA_W-1:0]    fin_data,
  output logic [COMMIT_W-1:0]        cm_valid,
  output logic [COMMIT_W*REG_W-1:0]  cm_dest,
  output logic [COMMIT_W*DATA_W-1:0] cm_data,
  output logic [COMMIT_W-1:0]        cm_store,
  output logic                       mem_req_valid,
  output logic [DATA_W-1:0]          mem_req_data,
  output logic [REG_W-1:0]           mem_req_dest,
  input  logic                       mem_ack,
  output logic [CMC_W-1:0]           retire_cnt,
  input  logic                       irq_req,
  output logic                       irq_saved
);

  typedef enum logic [1:0] {M_RUN, M_DRAIN, M_SAVED} mode_t;
  mode_t mode;

  logic [DEPTH-1:0]    e_val, e_done, e_st;
  logic [REG_W-1:0]    e_dest [DEPTH];
  logic [DATA_W-1:0]   e_data [DEPTH];
  logic [IDX_W-1:0]    head, tail;
  logic [CNT_W-1:0]    occ;

  logic [REG_W-1:0]    q_dest [RQ_DEPTH];
  logic [DATA_W-1:0]   q_data [RQ_DEPTH];
  logic [RQ_IDX_W-1:0] q_rd, q_wr;
  logic [RQ_CNT_W-1:0] q_cnt;

  logic [7:0]          n_cm, n_st, q_free;
  logic [RQ_IDX_W-1:0] st_off [COMMIT_W];
  logic [IDX_W-1:0]    cidx;
  logic                go, q_pop;

  assign q_free        = 8'(RQ_DEPTH) - 8'(q_cnt);
  assign q_pop         = mem_ack && (q_cnt != '0);
  assign alloc_base    = tail;
  assign alloc_grant   = (mode == M_RUN) && !irq_req && (alloc_cnt != '0) &&
                         (CNT_W'(alloc_cnt) <= (CNT_W'(DEPTH) - occ));
  assign mem_req_valid = (q_cnt != '0);
  assign mem_req_data  = q_data[q_rd];
  assign mem_req_dest  = q_dest[q_rd];
  assign retire_cnt    = CMC_W'(n_cm - n_st + {7'd0, q_pop});
  assign irq_saved     = (mode == M_SAVED);

  // head scan: longest finished run, capped by lanes and retire-queue room
  always_comb begin
    go       = 1'b1;
    n_cm     = '0;
    n_st     = '0;
    cidx     = head;
    cm_valid = '0;
    cm_store = '0;
    cm_dest  = '0;
    cm_data  = '0;
    for (int k = 0; k < COMMIT_W; k++) begin
      cidx      = head + IDX_W'(k);
      st_off[k] = RQ_IDX_W'(n_st);
      if (go && e_val[cidx] && e_done[cidx] && (!e_st[cidx] || (n_st < q_free))) begin
        cm_valid[k]                    = 1'b1;
        cm_store[k]                    = e_st[cidx];
        cm_dest[k*REG_W +: REG_W]      = e_dest[cidx];
        cm_data[k*DATA_W +: DATA_W]    = e_data[cidx];
        n_cm                           = n_cm + 8'd1;
        if (e_st[cidx]) n_st           = n_st + 8'd1;
      end else begin
        go = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_val  <= '0;
      e_done <= '0;
      e_st   <= '0;
      head   <= '0;
      tail   <= '0;
      occ    <= '0;
      mode   <= M_RUN;
    end else begin
      for (int k = 0; k < COMMIT_W; k++)
        if (cm_valid[k]) e_val[head + IDX_W'(k)] <= 1'b0;
      for (int f = 0; f < FIN_W; f++)
        if (fin_valid[f] && e_val[fin_idx[f*IDX_W +: IDX_W]])
          e_done[fin_idx[f*IDX_W +: IDX_W]] <= 1'b1;
      for (int k = 0; k < ISSUE_W; k++)
        if (alloc_grant && (k < int'(alloc_cnt))) begin
          e_val[tail + IDX_W'(k)]  <= 1'b1;
          e_done[tail + IDX_W'(k)] <= 1'b0;
          e_st[tail + IDX_W'(k)]   <= alloc_store[k];
        end
      head <= head + IDX_W'(n_cm);
      tail <= tail + (alloc_grant ? IDX_W'(alloc_cnt) : IDX_W'(0));
      occ  <= occ + (alloc_grant ? CNT_W'(alloc_cnt) : CNT_W'(0)) - CNT_W'(n_cm);
      case (mode)
        M_RUN:   if (irq_req) mode <= M_DRAIN;
        M_DRAIN: if (occ == '0 && q_cnt == '0) mode <= M_SAVED;
        default: mode <= M_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int f = 0; f < FIN_W; f++)
      if (fin_valid[f] && e_val[fin_idx[f*IDX_W +: IDX_W]])
        e_data[fin_idx[f*IDX_W +: IDX_W]] <= fin_data[f*DATA_W +: DATA_W];
    for (int k = 0; k < ISSUE_W; k++)
      if (alloc_grant && (k < int'(alloc_cnt)))
        e_dest[tail + IDX_W'(k)] <= alloc_dest[k*REG_W +: REG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rd  <= '0;
      q_wr  <= '0;
      q_cnt <= '0;
    end else begin
      q_rd  <= q_rd + RQ_IDX_W'(q_pop);
      q_wr  <= q_wr + RQ_IDX_W'(n_st);
      q_cnt <= q_cnt + RQ_CNT_W'(n_st) - RQ_CNT_W'(q_pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < COMMIT_W; k++)
      if (cm_store[k]) begin
        q_data[q_wr + st_off[k]] <= cm_data[k*DATA_W +: DATA_W];
        q_dest[q_wr + st_off[k]] <= cm_dest[k*REG_W +: REG_W];
      end
  end

  assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));
  assert_lane_prefix_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cm_valid + 1'b1) & cm_valid) == '0);
  assert_queue_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= RQ_CNT_W'(RQ_DEPTH));
  assert_no_grant_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_RUN) |-> !alloc_grant);
  assert_saved_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_saved |-> (occ == '0 && q_cnt == '0));
  assert_saved_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_saved |=> !irq_saved);

endmodule

// File: tb/commit_retire_buf_test.sv
`timescale 1ns/1ps
module commit_retire_buf_test;
  localparam int D = 8, IW = 3, CW = 2, FW = 2, RQ = 2, RW = 4, DW = 16;

  logic clk = 0, rst_n = 0;
  logic [1:0]     alloc_cnt;
  logic [IW-1:0]  alloc_store;
  logic [IW*RW-1:0] alloc_dest;
  logic           alloc_grant;
  logic [2:0]     alloc_base;
  logic [FW-1:0]  fin_valid;
  logic [FW*3-1:0] fin_idx;
  logic [FW*DW-1:0] fin_data;
  logic [CW-1:0]  cm_valid, cm_store;
  logic [CW*RW-1:0] cm_dest;
  logic [CW*DW-1:0] cm_data;
  logic           mem_req_valid, mem_ack, irq_req, irq_saved;
  logic [DW-1:0]  mem_req_data;
  logic [RW-1:0]  mem_req_dest;
  logic [1:0]     retire_cnt;

  commit_retire_buf #(.DEPTH(D), .ISSUE_W(IW), .COMMIT_W(CW), .FIN_W(FW),
    .RQ_DEPTH(RQ), .REG_W(RW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_store(alloc_store),
    .alloc_dest(alloc_dest), .alloc_grant(alloc_grant), .alloc_base(alloc_base),
    .fin_valid(fin_valid), .fin_idx(fin_idx), .fin_data(fin_data),
    .cm_valid(cm_valid), .cm_dest(cm_dest), .cm_data(cm_data), .cm_store(cm_store),
    .mem_req_valid(mem_req_valid), .mem_req_data(mem_req_data),
    .mem_req_dest(mem_req_dest), .mem_ack(mem_ack), .retire_cnt(retire_cnt),
    .irq_req(irq_req), .irq_saved(irq_saved));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, dseq = 0, fseq = 0;
  bit mv[D], md[D], ms[D];
  int mdest[D], mdata[D];
  int mh = 0, mt = 0, mocc = 0, mode = 0;
  int qd[$], qr[$];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cycle(input int req, input bit [2:0] stm, input int f0, input int f1,
                       input bit ack, input bit irq);
    int fi[2];
    int fdv[2];
    int en, es, fr, i, g, blk;
    fi[0] = f0; fi[1] = f1;
    @(negedge clk);
    alloc_cnt = 2'(req); alloc_store = stm; irq_req = irq; mem_ack = ack;
    for (int k = 0; k < IW; k++) alloc_dest[k*RW +: RW] = RW'(dseq + k);
    fin_valid = '0;
    for (int p = 0; p < FW; p++) begin
      fdv[p] = (fseq * 97 + p * 13 + 5) & 16'hffff;
      fin_valid[p] = fi[p] >= 0;
      fin_idx[p*3 +: 3] = 3'(fi[p] < 0 ? 0 : fi[p]);
      fin_data[p*DW +: DW] = DW'(fdv[p]);
    end
    fseq++;
    #1;
    g = (mode == 0 && !irq && req != 0 && mocc + req <= D) ? 1 : 0;
    chk((mode != 0 || irq) ? "R9 grant" : "R1 grant", int'(alloc_grant), g);
    if (req != 0) chk("R1 base", int'(alloc_base), mt);
    en = 0; es = 0; fr = RQ - qd.size(); blk = 0;
    for (int k = 0; k < CW; k++) begin
      i = (mh + k) % D;
      if (mv[i] && md[i] && (!ms[i] || es < fr)) begin
        en++; if (ms[i]) es++;
      end else begin
        if (mv[i] && md[i]) blk = 1;
        break;
      end
    end
    chk(blk ? "R8 commit count" : ((mv[mh] && !md[mh]) ? "R2 commit count" : "R4 commit count"),
        int'(cm_valid), (1 << en) - 1);
    for (int k = 0; k < en; k++) begin
      i = (mh + k) % D;
      chk("R3 lane dest", int'(cm_dest[k*RW +: RW]), mdest[i]);
      chk("R5 lane data", int'(cm_data[k*DW +: DW]), mdata[i]);
      chk("R6 lane store", int'(cm_store[k]), int'(ms[i]));
    end
    chk("R7 retire count", int'(retire_cnt), (en - es) + ((ack && qd.size() > 0) ? 1 : 0));
    chk("R6 mem valid", int'(mem_req_valid), qd.size() > 0 ? 1 : 0);
    if (qd.size() > 0) begin
      chk("R6 mem data", int'(mem_req_data), qd[0]);
      chk("R6 mem dest", int'(mem_req_dest), qr[0]);
    end
    chk("R10 saved", int'(irq_saved), mode == 2 ? 1 : 0);
    // model update
    if (ack && qd.size() > 0) begin void'(qd.pop_front()); void'(qr.pop_front()); end
    for (int k = 0; k < en; k++) begin
      i = (mh + k) % D;
      mv[i] = 0;
      if (ms[i]) begin qd.push_back(mdata[i]); qr.push_back(mdest[i]); end
    end
    for (int p = 0; p < FW; p++)
      if (fi[p] >= 0 && mv[fi[p]]) begin md[fi[p]] = 1; mdata[fi[p]] = fdv[p]; end
    if (g) begin
      for (int k = 0; k < req; k++) begin
        i = (mt + k) % D;
        mv[i] = 1; md[i] = 0; ms[i] = stm[k]; mdest[i] = (dseq + k) & 15;
      end
      mt = (mt + req) % D; dseq += req;
    end
    mh = (mh + en) % D;
    mocc = mocc + (g ? req : 0) - en;
    if (mode == 0) begin if (irq) mode = 1; end
    else if (mode == 1) begin if (mocc + en - (g ? req : 0) == 0 && qd.size() + (ack && 1) * 0 == qd.size() && 0) mode = 1; end
  endtask

  // mode transitions use the pre-update occupancy, so they are kept separately
  int pre_occ, pre_q;
  task automatic step(input int req, input bit [2:0] stm, input int f0, input int f1,
                      input bit ack, input bit irq);
    int m0;
    m0 = mode; pre_occ = mocc; pre_q = qd.size();
    cycle(req, stm, f0, f1, ack, irq);
    if (m0 == 1) mode = (pre_occ == 0 && pre_q == 0) ? 2 : 1;
    else if (m0 == 2) mode = 0;
  endtask

  task automatic pick2(output int a, output int b, input int pct);
    int c[$];
    int j;
    a = -1; b = -1;
    for (int k = 0; k < D; k++) if (mv[k] && !md[k]) c.push_back(k);
    if (c.size() > 0 && int'($urandom % 100) < pct) begin
      j = int'($urandom % c.size()); a = c[j]; c.delete(j);
    end
    if (c.size() > 0 && int'($urandom % 100) < pct) begin
      j = int'($urandom % c.size()); b = c[j];
    end
  endtask

  task automatic settle();
    int a, b;
    for (int n = 0; n < 60; n++) begin
      if (mocc == 0 && qd.size() == 0 && mode == 0) break;
      pick2(a, b, 100);
      step(0, 3'b000, a, b, 1, 0);
    end
  endtask

  task automatic traffic(input int n, input int spct, input int fpct, input int apct);
    int a, b, r;
    bit [2:0] s;
    for (int c = 0; c < n; c++) begin
      pick2(a, b, fpct);
      r = int'($urandom % 4);
      for (int k = 0; k < 3; k++) s[k] = int'($urandom % 100) < spct;
      step(r, s, a, b, int'($urandom % 100) < apct, 0);
    end
  endtask

  initial begin
    int base, p[3];
    alloc_cnt = 0; alloc_store = 0; alloc_dest = 0; fin_valid = 0; fin_idx = 0;
    fin_data = 0; mem_ack = 0; irq_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11 reset cm_valid", int'(cm_valid), 0);
    chk("R11 reset mem_req_valid", int'(mem_req_valid), 0);
    chk("R11 reset irq_saved", int'(irq_saved), 0);
    chk("R11 reset base", int'(alloc_base), 0);
    chk("R11 reset retire", int'(retire_cnt), 0);

    // R1 fill to full, refusal without partial grant
    step(3, 0, -1, -1, 0, 0);
    step(3, 0, -1, -1, 0, 0);
    step(3, 0, -1, -1, 0, 0);
    step(2, 0, -1, -1, 0, 0);
    step(1, 0, -1, -1, 0, 0);
    // R2 finish a younger entry only: nothing may complete
    step(0, 0, 3, 5, 0, 0);
    step(0, 0, -1, -1, 0, 0);
    settle();

    // R3 R4 every finish order of a three-entry group
    for (int x = 0; x < 3; x++)
      for (int y = 0; y < 3; y++)
        for (int z = 0; z < 3; z++)
          if (x != y && y != z && x != z) begin
            base = mt; p[0] = x; p[1] = y; p[2] = z;
            step(3, 0, -1, -1, 0, 0);
            for (int k = 0; k < 3; k++) step(0, 0, (base + p[k]) % D, -1, 0, 0);
            step(0, 0, -1, -1, 0, 0);
            step(0, 0, -1, -1, 0, 0);
            settle();
          end
    // R4 two finished together then a cap of two lanes over three done
    base = mt;
    step(3, 0, -1, -1, 0, 0);
    step(0, 0, (base + 2) % D, (base + 1) % D, 0, 0);
    step(0, 0, base, -1, 0, 0);
    step(0, 0, -1, -1, 0, 0);
    step(0, 0, -1, -1, 0, 0);
    settle();

    // R6 R8 stores with the acknowledge held low
    base = mt;
    step(3, 3'b111, -1, -1, 0, 0);
    step(0, 0, base, (base + 1) % D, 0, 0);
    step(0, 0, (base + 2) % D, -1, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, -1, -1, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, -1, -1, 1, 0);
    settle();

    // R9 R10 interrupt with entries in flight
    base = mt;
    step(3, 3'b010, -1, -1, 0, 0);
    step(2, 0, base, -1, 0, 1);
    for (int n = 0; n < 40 && mode != 2; n++) begin
      int a, b;
      pick2(a, b, 60);
      step(1, 0, a, b, n % 2 == 1, 0);
    end
    step(1, 0, -1, -1, 0, 0);
    step(2, 0, -1, -1, 0, 0);
    settle();
    // R10 interrupt on an empty buffer
    step(0, 0, -1, -1, 0, 1);
    step(1, 0, -1, -1, 0, 0);
    step(1, 0, -1, -1, 0, 0);
    step(1, 0, -1, -1, 0, 0);
    settle();

    // mixed sweeps
    traffic(1500, 30, 50, 50);
    settle();
    traffic(800, 80, 70, 20);
    settle();
    for (int r = 0; r < 20; r++) begin
      traffic(30, 40, 60, 50);
      step(int'($urandom % 4), 3'b001, -1, -1, 1, 1);
      for (int n = 0; n < 60 && mode != 0; n++) begin
        int a, b;
        pick2(a, b, 70);
        step(int'($urandom % 4), 0, a, b, 1, 0);
      end
    end
    settle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule